// File: doc/BRIEF.md
# Unlock-Enabled Watchdog Timer

This block is a watchdog for a small processor core. It is dormant after any reset. Software starts it only by writing a two-byte key, 0x1E and then 0xE1, to one special-function register address. Once started, a 13-bit counter advances on each machine-cycle tick. When the counter wraps, the block raises an active-high reset pulse that lasts a fixed number of clocks. The pulse is meant to drive the chip's reset pin.

Software keeps the watchdog from firing by writing the same key again before the count runs out. Nothing software can write stops the watchdog. Only an external reset, or the watchdog's own overflow, returns it to the dormant state. The tick is an input strobe, typically one pulse every twelve oscillator clocks, so the block runs on the core clock and counts only qualified cycles.

Top module: `unlock_wdt`

## Requirements
- R1: While `rst_ni` is low, `wdt_rst_o` is low with no clock edge needed. After release the watchdog is dormant and its key sequencer waits for a first key byte.
- R2: While dormant, `wdt_rst_o` stays low no matter how many ticks arrive.
- R3: Two write cycles to address 0xA6 make the watchdog active with its count at zero: data 0x1E, then data 0xE1. Writes to any other address between them do not disturb the sequence.
- R4: While active, the count rises by one on each clock edge where `mc_tick_i` is high. Edges without a tick leave the count unchanged. The count is 13 bits wide, so overflow comes on the 8192nd tick after it was last zeroed.
- R5: Once active, no write stops or slows the watchdog. Any write that is not a full key sequence leaves the count untouched.
- R6: A tick that arrives with the count at 8191 makes `wdt_rst_o` go high from the next clock edge. It stays high for PULSE_LEN clocks (default 4). The same edge makes the watchdog dormant and clears the count.
- R7: A full key sequence written while active clears the count to zero and keeps the watchdog active.
- R8: After 0x1E at 0xA6, any write to 0xA6 of a value other than 0x1E or 0xE1 discards the sequence, so a following 0xE1 has no effect. A repeated 0x1E keeps the sequencer waiting for 0xE1.
- R9: Writes made while `wdt_rst_o` is high are ignored.
- R10: If an overflow tick and the completing 0xE1 write fall in the same cycle, the overflow wins. The pulse is emitted and the watchdog ends dormant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mc_tick_i | input | 1 | Machine-cycle strobe, one clock wide |
| sfr_we_i | input | 1 | Register write strobe |
| sfr_addr_i | input | 8 | Register write address |
| sfr_wdata_i | input | 8 | Register write data |
| wdt_rst_o | output | 1 | Active-high reset pulse on overflow |

## Verification
The count itself is not visible at the ports. A wrong count, a missed tick, or a refresh that did not clear the count shows up only as a pulse that comes early, late, or never. That can be as much as 8192 ticks after the fault. So the bench times the first pulse to the exact cycle and counts its width. A sequencer left in the wrong state shows up when the next 0xE1 either starts a watchdog that should stay dormant or fails to start one. The bench therefore runs past a full count period after each such write to prove that no pulse appears.

// File: rtl/uwdt_pkg.sv
package uwdt_pkg;
  typedef enum logic {
    KEY_WAIT_FIRST  = 1'b0,
    KEY_WAIT_SECOND = 1'b1
  } key_state_e;
endpackage

// File: rtl/uwdt_rst_sync.sv
module uwdt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/uwdt_key.sv
module uwdt_key
  import uwdt_pkg::*;
#(
  parameter int          ADDR_W  = 8,
  parameter int          DATA_W  = 8,
  parameter logic [7:0]  REG_ADR = 8'hA6,
  parameter logic [7:0]  KEY_LO  = 8'h1E,
  parameter logic [7:0]  KEY_HI  = 8'hE1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              block_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              key_ok_o
);
  localparam logic [ADDR_W-1:0] ADR_MATCH = ADDR_W'(REG_ADR);
  localparam logic [DATA_W-1:0] FIRST_KEY = DATA_W'(KEY_LO);
  localparam logic [DATA_W-1:0] LAST_KEY  = DATA_W'(KEY_HI);

  key_state_e state_q, state_d;
  logic       reg_hit;
  logic       key_ok;

  assign reg_hit = we_i && !block_i && (addr_i == ADR_MATCH);

  always_comb begin
    state_d = state_q;
    key_ok  = 1'b0;
    if (clr_i) begin
      state_d = KEY_WAIT_FIRST;
    end else if (reg_hit) begin
      if (data_i == FIRST_KEY) begin
        state_d = KEY_WAIT_SECOND;
      end else if ((state_q == KEY_WAIT_SECOND) && (data_i == LAST_KEY)) begin
        key_ok  = 1'b1;
        state_d = KEY_WAIT_FIRST;
      end else begin
        state_d = KEY_WAIT_FIRST;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= KEY_WAIT_FIRST;
    else         state_q <= state_d;
  end

  assign key_ok_o = key_ok;

  assert_break_seq_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == KEY_WAIT_SECOND && we_i && !block_i && addr_i == ADR_MATCH &&
     data_i != FIRST_KEY && data_i != LAST_KEY) |=> (state_q == KEY_WAIT_FIRST));

  assert_no_key_when_blocked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_i |-> !key_ok_o);

  assert_wrong_addr_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && (!we_i || addr_i != ADR_MATCH)) |=> $stable(state_q));
endmodule

// File: rtl/uwdt_count.sv
module uwdt_count #(
  parameter int CNT_W = 13
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic key_ok_i,
  output logic ovf_o,
  output logic active_o
);
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             act_q, act_d;
  logic             ovf;
  logic             cnt_en;

  assign ovf    = act_q && tick_i && (cnt_q == CNT_TOP);
  assign cnt_en = ovf || key_ok_i || (act_q && tick_i);

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    if (ovf) begin
      act_d = 1'b0;
      cnt_d = '0;
    end else if (key_ok_i) begin
      act_d = 1'b1;
      cnt_d = '0;
    end else if (act_q && tick_i) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (cnt_en) begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

  assign ovf_o    = ovf;
  assign active_o = act_q;

  assert_no_self_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act_q && !key_ok_i) |=> !act_q);

  assert_stays_active_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && !ovf_o) |=> act_q);

  assert_count_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && tick_i && !ovf_o && !key_ok_i) |=> (cnt_q == $past(cnt_q) + 1'b1));

  assert_count_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && !tick_i && !key_ok_i) |=> $stable(cnt_q));

  assert_refresh_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_ok_i && !ovf_o) |=> (act_q && cnt_q == '0));

  assert_ovf_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> (!act_q && cnt_q == '0));
endmodule

// File: rtl/uwdt_pulse.sv
module uwdt_pulse #(
  parameter int PULSE_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ovf_i,
  output logic pulse_o
);
  localparam int PW = (PULSE_LEN > 1) ? $clog2(PULSE_LEN + 1) : 1;

  generate
    if (PULSE_LEN == 1) begin : g_flop
      logic pls_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pls_q <= 1'b0;
        else         pls_q <= ovf_i;
      end
      assign pulse_o = pls_q;
    end else begin : g_stretch
      localparam logic [PW-1:0] LEN_V = PW'(PULSE_LEN);
      logic [PW-1:0] left_q, left_d;
      logic          pls_q, pls_d;
      logic          upd_en;

      assign upd_en = ovf_i || pls_q;

      always_comb begin
        left_d = left_q;
        if (ovf_i)             left_d = LEN_V;
        else if (left_q != '0) left_d = left_q - 1'b1;
        pls_d = (left_d != '0);
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          left_q <= '0;
          pls_q  <= 1'b0;
        end else if (upd_en) begin
          left_q <= left_d;
          pls_q  <= pls_d;
        end
      end
      assign pulse_o = pls_q;

      assert_pulse_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ovf_i && left_q <= 1) |=> !pulse_o);
    end
  endgenerate

  assert_pulse_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> pulse_o);
endmodule

// File: rtl/unlock_wdt.sv
module unlock_wdt #(
  parameter int         CNT_W     = 13,
  parameter int         PULSE_LEN = 4,
  parameter int         SYNC_LEN  = 2,
  parameter int         ADDR_W    = 8,
  parameter int         DATA_W    = 8,
  parameter logic [7:0] REG_ADR   = 8'hA6,
  parameter logic [7:0] KEY_LO    = 8'h1E,
  parameter logic [7:0] KEY_HI    = 8'hE1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mc_tick_i,
  input  logic              sfr_we_i,
  input  logic [ADDR_W-1:0] sfr_addr_i,
  input  logic [DATA_W-1:0] sfr_wdata_i,
  output logic              wdt_rst_o
);
  logic rst_n_int;
  logic key_ok;
  logic ovf;
  logic active;
  logic pulse;

  uwdt_rst_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n_int)
  );

  uwdt_key #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W),
    .REG_ADR(REG_ADR), .KEY_LO(KEY_LO), .KEY_HI(KEY_HI)
  ) u_key (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_int),
    .clr_i    (ovf),
    .block_i  (pulse),
    .we_i     (sfr_we_i),
    .addr_i   (sfr_addr_i),
    .data_i   (sfr_wdata_i),
    .key_ok_o (key_ok)
  );

  uwdt_count #(.CNT_W(CNT_W)) u_count (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_int),
    .tick_i   (mc_tick_i),
    .key_ok_i (key_ok),
    .ovf_o    (ovf),
    .active_o (active)
  );

  uwdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_int),
    .ovf_i   (ovf),
    .pulse_o (pulse)
  );

  assign wdt_rst_o = pulse;

  assert_rst_out_low_R1: assert property (@(posedge clk_i)
    !rst_n_int |-> !wdt_rst_o);

  assert_dormant_in_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    wdt_rst_o |-> !active);
endmodule

// File: tb/unlock_wdt_tb_top.sv
module unlock_wdt_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 13;
  localparam int L          = 4;
  localparam int FULL       = 1 << W;
  localparam int QUIET      = FULL + 300;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic       we;
  logic [7:0] addr;
  logic [7:0] wdata;
  logic       pulse;
  int         n_chk = 0;
  int         n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  unlock_wdt #(.CNT_W(W), .PULSE_LEN(L)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mc_tick_i(tick), .sfr_we_i(we),
    .sfr_addr_i(addr), .sfr_wdata_i(wdata), .wdt_rst_o(pulse)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset output low", int'(pulse), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic t);
    @(negedge clk);
    tick = t; we = 1'b1; addr = a; wdata = d;
  endtask

  task automatic unlock();
    wr(8'hA6, 8'h1E, 1'b0);
    wr(8'hA6, 8'hE1, 1'b0);
  endtask

  task automatic run(input int n, input int per, output int hi, output int first);
    hi = 0; first = -1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pulse) begin
        hi++;
        if (first < 0) first = i;
      end
      we = 1'b0;
      tick = ((i % per) == 0);
    end
  endtask

  task automatic t_idle();
    int hi, fi;
    do_reset();
    run(QUIET, 1, hi, fi);
    chk("R2 no pulse while dormant", hi, 0);
  endtask

  task automatic t_overflow();
    int hi, fi;
    do_reset();
    unlock();
    run(FULL + L + 4, 1, hi, fi);
    chk("R3/R4 first pulse after 8192 ticks", fi, FULL);
    chk("R6 pulse width", hi, L);
    run(QUIET, 1, hi, fi);
    chk("R6 dormant after overflow", hi, 0);
  endtask

  task automatic t_sparse();
    int hi, fi;
    do_reset();
    unlock();
    run(3 * (FULL - 1) + L + 8, 3, hi, fi);
    chk("R4 only ticked cycles count", fi, 3 * (FULL - 1) + 1);
    chk("R4 pulse width sparse", hi, L);
  endtask

  task automatic t_refresh();
    int hi, fi;
    do_reset();
    unlock();
    run(5000, 1, hi, fi);
    chk("R7 no pulse before refresh", hi, 0);
    unlock();
    run(FULL + L + 4, 1, hi, fi);
    chk("R7 refresh restarts count", fi, FULL);
  endtask

  task automatic t_no_sw_off();
    int hi, fi;
    do_reset();
    unlock();
    run(100, 1, hi, fi);
    wr(8'hA6, 8'h00, 1'b0);
    wr(8'hA6, 8'h1E, 1'b0);
    wr(8'hA6, 8'hFF, 1'b0);
    wr(8'hA6, 8'hE1, 1'b0);
    wr(8'h55, 8'hE1, 1'b0);
    run(FULL + L, 1, hi, fi);
    chk("R5 stray writes neither stop nor clear", fi, FULL - 100);
    chk("R5 pulse width", hi, L);
  endtask

  task automatic t_broken();
    int hi, fi;
    do_reset();
    wr(8'hA6, 8'h1E, 1'b0);
    wr(8'hA6, 8'h55, 1'b0);
    wr(8'hA6, 8'hE1, 1'b0);
    run(QUIET, 1, hi, fi);
    chk("R8 broken sequence leaves dormant", hi, 0);
    wr(8'hA6, 8'h1E, 1'b0);
    wr(8'h30, 8'h99, 1'b0);
    wr(8'hA6, 8'hE1, 1'b0);
    run(FULL + L, 1, hi, fi);
    chk("R3 other address does not break key", fi, FULL);
    wr(8'hA6, 8'h1E, 1'b0);
    wr(8'hA6, 8'h1E, 1'b0);
    wr(8'hA6, 8'hE1, 1'b0);
    run(FULL + L, 1, hi, fi);
    chk("R8 repeated first byte keeps sequence", fi, FULL);
  endtask

  task automatic t_pulse_block();
    int hi, fi;
    do_reset();
    unlock();
    run(FULL, 1, hi, fi);
    wr(8'hA6, 8'h1E, 1'b0);
    wr(8'hA6, 8'hE1, 1'b0);
    run(QUIET, 1, hi, fi);
    chk("R9 remaining pulse cycles", hi, L - 2);
    chk("R9 pulse still running", fi, 0);
  endtask

  task automatic t_priority();
    int hi, fi;
    do_reset();
    unlock();
    run(FULL - 1, 1, hi, fi);
    wr(8'hA6, 8'h1E, 1'b0);
    wr(8'hA6, 8'hE1, 1'b1);
    run(QUIET, 1, hi, fi);
    chk("R10 overflow beats refresh", fi, 0);
    chk("R10 single pulse then dormant", hi, L);
  endtask

  task automatic t_async();
    int hi, fi;
    do_reset();
    unlock();
    run(FULL, 1, hi, fi);
    @(negedge clk);
    chk("R6 pulse high after overflow", int'(pulse), 1);
    we = 1'b0; tick = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R1 reset clears pulse at once", int'(pulse), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run(QUIET, 1, hi, fi);
    chk("R1 dormant after reset", hi, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    t_idle();
    t_overflow();
    t_sparse();
    t_refresh();
    t_no_sw_off();
    t_broken();
    t_pulse_block();
    t_priority();
    t_async();
    summary();
    $finish;
  end
endmodule